// File: doc/BRIEF.md
# Reduced UART Register Front-End

This block is the software-facing side of a cut-down UART. A 32-bit register bus reaches seven word registers: a data port, a receive-status word, a flag word, an interrupt mask, raw and masked interrupt status, and a write-only interrupt clear. Writing the data port puts a byte into an outgoing queue, which an external agent drains. Reading the data port takes a byte from an incoming queue, which an external agent fills. Both queues are small synchronous FIFOs inside the block.

There is no serial line. Queue occupancy drives every flag bit and every raw interrupt bit. The interrupt output is a one-cycle pulse. A shadow register holds the masked interrupt bits that have already been signalled, and a pulse is raised only when a masked bit appears that the shadow does not yet hold. The block works as a bridge between a level-style status model and an interrupt controller that only accepts edges.

Bus accesses complete in the cycle they are presented. Read data and the error flag are combinational from the request, and the state they cause changes at the next clock edge.

Top module: `uart_lite_regs`

## Requirements
- R1: A read of DATA (byte offset 0x00) returns the oldest incoming byte in bits [7:0] and removes it from the incoming queue. When the incoming queue is empty the read returns 0 and changes nothing.
- R2: A write to DATA appends bits [7:0] of the write data to the outgoing queue. When that queue is full the byte is dropped and the queue is unchanged.
- R3: FLAG (0x08) reads 0 in bits [31:5]. Bit 0 is set when the incoming queue is empty, bit 1 when it is full, bit 2 when the outgoing queue is empty and bit 3 when it is full. Every status bit follows the queue occupancy at all times.
- R4: FLAG bit 4 (busy) is set by every write to DATA, including a dropped one. It clears when an agent pop leaves the outgoing queue empty.
- R5: Raw interrupt bit 0 (receive) is set by every byte the agent adds to the incoming queue. It is cleared when a DATA read leaves that queue empty.
- R6: Raw interrupt bit 1 (transmit) is set by every byte the agent takes from the outgoing queue. It is cleared when a DATA write leaves that queue full.
- R7: RXSTAT (0x04) always reads 0. Writes to RXSTAT, FLAG, RAW (0x10) and MIS (0x14) are accepted without error and change nothing.
- R8: A read of CLR (0x18) returns an error and 0. A write to CLR clears each raw bit whose write-data bit is 1. A set event in the same cycle overrides the clear.
- R9: MASK (0x0C) holds bits [1:0] of the last value written to it. MIS reads the raw bits ANDed with MASK, both taken from the same cycle.
- R10: The irq output is high for exactly one cycle, and only when a masked interrupt bit is set that was clear in the shadow of bits already signalled. Clearing one bit while another stays set gives no pulse. Mask writes, clear writes and queue events can all raise a pulse.
- R11: The shadow drops any bit that is no longer asserted, so a bit that falls and later rises again pulses again.
- R12: An access to an offset that is not word-aligned, or that lies at 0x1C or above, returns an error and reads 0. It has no effect.
- R13: The agent side: tx_avail is high when the outgoing queue holds a byte, and tx_data shows the oldest byte. tx_pop on an empty queue is ignored. rx_push into a full incoming queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | BUS_W | Write data |
| rsp_rdata | output | BUS_W | Read data, same cycle |
| rsp_err | output | 1 | Error response, same cycle |
| rx_push | input | 1 | Agent adds a byte to the incoming queue |
| rx_push_data | input | BYTE_W | Byte to add |
| tx_pop | input | 1 | Agent takes a byte from the outgoing queue |
| tx_avail | output | 1 | Outgoing queue is not empty |
| tx_data | output | BYTE_W | Oldest outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle the bound assertions check these behaviours:
- error responses on unmapped offsets and on reads of CLR;
- the zero result of an empty DATA read, and that such a read leaves the incoming queue untouched;
- that a write into a full outgoing queue is dropped;
- that busy tracks outgoing occupancy;
- that a pulse is always preceded by a nonzero masked status.

Some behaviours only the bench's scenarios can show, because they need a reference queue and an interrupt history. These are:
- byte ordering through both queues;
- exactly when the raw bits are set and cleared;
- that a pulse fires exactly once per newly asserted masked bit;
- that no pulse fires when one of two bits is cleared.

// File: rtl/uart_lite_pkg.sv
// Shared register selects and bit positions for the reduced UART front-end.
// Assumes a word-aligned map of seven registers starting at offset 0.
package uart_lite_pkg;
    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_RSTAT = 3'd1,
        SEL_FLAG  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_RAW   = 3'd4,
        SEL_MIS   = 3'd5,
        SEL_CLR   = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    localparam int FLG_RXE = 0;
    localparam int FLG_RXF = 1;
    localparam int FLG_TXE = 2;
    localparam int FLG_TXF = 3;
    localparam int FLG_BSY = 4;
    localparam int FLAG_W  = 5;

    localparam int IRQ_RX  = 0;
    localparam int IRQ_TX  = 1;
    localparam int IRQ_W   = 2;
endpackage

// File: rtl/uart_lite_fifo.sv
// Synchronous byte FIFO with occupancy count.
// Assumes DEPTH >= 2. A push into a full FIFO is refused even if a pop
// happens in the same cycle, and a pop from an empty FIFO is refused.
module uart_lite_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full,
    output logic                         push_ok,
    output logic                         pop_ok
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];
    assign count   = cnt_q;

    // Store the accepted byte.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end
endmodule

// File: rtl/uart_lite_irq_edge.sv
// Turns a level-style masked interrupt vector into single-cycle pulses.
// A shadow keeps the bits already signalled. The shadow follows the vector
// every cycle, so bits that fall are forgotten and can pulse again later.
module uart_lite_irq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] masked,
    output logic         irq
);
    logic [N-1:0] shadow_q;
    logic         irq_q;

    // Pulse on any bit that is newly set, then remember the current vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q    <= |(masked & ~shadow_q);
            shadow_q <= masked;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/uart_lite_regs.sv
// Register front-end of a reduced UART. A single-cycle 32-bit register bus
// reaches data, receive-status, flag, mask, raw, masked and clear registers.
// Two internal FIFOs stand in for the line. Flags come from occupancy, and
// raw interrupt bits are set or cleared by queue events. Assumes ADDR_W >= 5
// and both depths >= 2.
module uart_lite_regs
    import uart_lite_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int BYTE_W   = 8,
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              rsp_err,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_push_data,
    input  logic              tx_pop,
    output logic              tx_avail,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] REG_COUNT = IDX_W'(7);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  word_idx;
    logic              data_rd, data_wr, mask_wr, clr_wr;
    logic [BYTE_W-1:0] rx_head;
    logic [RX_CW-1:0]  rx_cnt;
    logic [TX_CW-1:0]  tx_cnt;
    logic              rx_empty, rx_full, rx_push_ok, rx_pop_ok;
    logic              tx_empty, tx_full, tx_push_ok, tx_pop_ok;
    logic              rx_now_empty, tx_now_full, tx_drained;
    logic [IRQ_W-1:0]  raw_q, mask_q, clr_vec, set_vec, drop_vec;
    logic              busy_q;
    logic [FLAG_W-1:0] flags;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata[BUS_W-1:BYTE_W];
    assign word_idx     = req_addr[ADDR_W-1:2];

    // Decode the byte offset into a register select.
    always_comb begin
        sel = SEL_NONE;
        if (req_addr[1:0] == 2'b00 && word_idx < REG_COUNT)
            sel = reg_sel_e'(word_idx[2:0]);
    end

    assign data_rd = req_valid && !req_write && (sel == SEL_DATA);
    assign data_wr = req_valid &&  req_write && (sel == SEL_DATA);
    assign mask_wr = req_valid &&  req_write && (sel == SEL_MASK);
    assign clr_wr  = req_valid &&  req_write && (sel == SEL_CLR);

    uart_lite_fifo #(.DW(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data), .pop(data_rd),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    uart_lite_fifo #(.DW(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(data_wr), .push_data(req_wdata[BYTE_W-1:0]), .pop(tx_pop),
        .head(tx_data), .count(tx_cnt), .empty(tx_empty), .full(tx_full),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    assign tx_avail = !tx_empty;

    // Detect the queue transitions that drop raw bits or clear busy.
    assign rx_now_empty = rx_pop_ok && !rx_push_ok && (rx_cnt == RX_CW'(1));
    assign tx_now_full  = tx_push_ok && !tx_pop_ok && (tx_cnt == TX_CW'(TX_DEPTH - 1));
    assign tx_drained   = tx_pop_ok && !tx_push_ok && (tx_cnt == TX_CW'(1));

    // Gather the raw-bit set, drop and clear vectors.
    always_comb begin
        set_vec          = '0;
        drop_vec         = '0;
        set_vec[IRQ_RX]  = rx_push_ok;
        set_vec[IRQ_TX]  = tx_pop_ok;
        drop_vec[IRQ_RX] = rx_now_empty;
        drop_vec[IRQ_TX] = tx_now_full;
        clr_vec          = clr_wr ? req_wdata[IRQ_W-1:0] : '0;
    end

    // Hold the raw status, mask and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
            busy_q <= 1'b0;
        end else begin
            raw_q <= (raw_q & ~clr_vec & ~drop_vec) | set_vec;
            if (mask_wr) mask_q <= req_wdata[IRQ_W-1:0];
            if (data_wr)         busy_q <= 1'b1;
            else if (tx_drained) busy_q <= 1'b0;
        end
    end

    // Assemble the flag word from occupancy and busy.
    always_comb begin
        flags          = '0;
        flags[FLG_RXE] = rx_empty;
        flags[FLG_RXF] = rx_full;
        flags[FLG_TXE] = tx_empty;
        flags[FLG_TXF] = tx_full;
        flags[FLG_BSY] = busy_q;
    end

    // Read mux and error response.
    always_comb begin
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        if (req_valid) begin
            unique case (sel)
                SEL_DATA:  if (!req_write && !rx_empty) rsp_rdata = BUS_W'(rx_head);
                SEL_RSTAT: rsp_rdata = '0;
                SEL_FLAG:  if (!req_write) rsp_rdata = BUS_W'(flags);
                SEL_MASK:  if (!req_write) rsp_rdata = BUS_W'(mask_q);
                SEL_RAW:   if (!req_write) rsp_rdata = BUS_W'(raw_q);
                SEL_MIS:   if (!req_write) rsp_rdata = BUS_W'(raw_q & mask_q);
                SEL_CLR:   rsp_err = !req_write;
                default:   rsp_err = 1'b1;
            endcase
        end
    end

    uart_lite_irq_edge #(.N(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .masked(raw_q & mask_q), .irq(irq)
    );
endmodule

// File: rtl/uart_lite_regs_chk.sv
// Property checker for the reduced UART front-end. It is attached by bind and
// reads the top's ports plus its queue counts, raw, mask and busy state.
module uart_lite_regs_chk
    import uart_lite_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int BUS_W    = 32,
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_write,
    input logic [ADDR_W-1:0]            req_addr,
    input logic [BUS_W-1:0]             rsp_rdata,
    input logic                         rsp_err,
    input logic                         rx_push,
    input logic                         tx_pop,
    input logic                         irq,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt,
    input logic [$clog2(TX_DEPTH+1)-1:0] tx_cnt,
    input logic [IRQ_W-1:0]             raw_q,
    input logic [IRQ_W-1:0]             mask_q,
    input logic                         busy_q
);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);

    logic is_mapped, rd_data, wr_data;
    assign is_mapped = (req_addr[1:0] == 2'b00) && (req_addr < ADDR_W'(28));
    assign rd_data   = req_valid && !req_write && (req_addr == '0);
    assign wr_data   = req_valid &&  req_write && (req_addr == '0);

    // R1
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_cnt == '0) |-> (rsp_rdata == '0 && !rsp_err));

    // R1
    empty_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && rx_cnt == '0 && !rx_push) |=> (rx_cnt == '0));

    // R2
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_cnt == TX_CW'(TX_DEPTH) && !tx_pop) |=> $stable(tx_cnt));

    // R4
    busy_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q == (tx_cnt != '0));

    // R12
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_mapped) |-> (rsp_err && rsp_rdata == '0));

    // R8
    clr_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(24)) |-> rsp_err);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(raw_q & mask_q)));

    // R13
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RX_CW'(RX_DEPTH));
endmodule

bind uart_lite_regs uart_lite_regs_chk #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rx_push(rx_push), .tx_pop(tx_pop), .irq(irq), .rx_cnt(rx_cnt),
    .tx_cnt(tx_cnt), .raw_q(raw_q), .mask_q(mask_q), .busy_q(busy_q)
);

// File: tb/uart_lite_regs_test.sv
`timescale 1ns/1ps
// Sweep bench for the reduced UART front-end. A queue model in the bench
// predicts read data, errors, flags, raw bits and the interrupt pulse count.
module uart_lite_regs_test;
    localparam int D = 4;
    localparam logic [4:0] A_DATA = 5'h00, A_RSTAT = 5'h04, A_FLAG = 5'h08,
                           A_MASK = 5'h0C, A_RAW = 5'h10, A_MIS = 5'h14,
                           A_CLR = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        rx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        tx_avail, irq;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;

    uart_lite_regs #(.ADDR_W(5), .BUS_W(32), .BYTE_W(8), .RX_DEPTH(D), .TX_DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_data(tx_data), .irq(irq)
    );

    int n_chk = 0, n_bad = 0, pulses = 0, exp_pulses = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic [1:0] m_raw = '0, m_mask = '0;

    // Count irq pulses, sampled mid-cycle.
    always @(negedge clk) if (rst_n && irq) pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic mapped(input logic [4:0] a);
        return (a[1:0] == 2'b00) && (a < 5'd28);
    endfunction

    function automatic logic [31:0] flags_exp();
        return {27'h0, txq.size() != 0, txq.size() == D, txq.size() == 0,
                rxq.size() == D, rxq.size() == 0};
    endfunction

    function automatic string tag_of(input logic wr, input logic [4:0] a);
        if (!mapped(a)) return "R12";
        case (a)
            A_DATA:  return wr ? "R2" : "R1";
            A_RSTAT: return "R7";
            A_FLAG:  return wr ? "R7" : "R3 R4";
            A_MASK:  return "R9";
            A_RAW:   return wr ? "R7" : "R5 R6";
            A_MIS:   return wr ? "R7" : "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic note_irq(input logic [1:0] old_mis);
        if (|((m_raw & m_mask) & ~old_mis)) exp_pulses++;
        chk("R10 pulse count", pulses, exp_pulses);
    endtask

    task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] wd);
        logic [31:0] exp_rd, got_rd;
        logic        exp_er, got_er;
        logic [1:0]  old_mis;
        string       tag;
        old_mis = m_raw & m_mask;
        exp_rd  = '0;
        exp_er  = 1'b0;
        tag     = tag_of(wr, a);
        if (!mapped(a)) exp_er = 1'b1;
        else if (wr) begin
            case (a)
                A_DATA: if (txq.size() < D) begin
                    txq.push_back(wd[7:0]);
                    if (txq.size() == D) m_raw[1] = 1'b0;
                end
                A_MASK: m_mask = wd[1:0];
                A_CLR:  m_raw  = m_raw & ~wd[1:0];
                default: ;
            endcase
        end else begin
            case (a)
                A_DATA: if (rxq.size() > 0) begin
                    exp_rd = {24'h0, rxq.pop_front()};
                    if (rxq.size() == 0) m_raw[0] = 1'b0;
                end
                A_FLAG: exp_rd = flags_exp();
                A_MASK: exp_rd = {30'h0, m_mask};
                A_RAW:  exp_rd = {30'h0, m_raw};
                A_MIS:  exp_rd = {30'h0, m_raw & m_mask};
                A_CLR:  exp_er = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #3;
        got_rd = rsp_rdata;
        got_er = rsp_err;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk); #1;
        if (!wr) chk({tag, " rdata"}, got_rd, exp_rd);
        chk({tag, " err"}, {31'h0, got_er}, {31'h0, exp_er});
        note_irq(old_mis);
    endtask

    task automatic agent_push(input logic [7:0] b);
        logic [1:0] old_mis;
        old_mis = m_raw & m_mask;
        if (rxq.size() < D) begin
            rxq.push_back(b);
            m_raw[0] = 1'b1;
        end
        @(negedge clk);
        rx_push = 1'b1; rx_push_data = b;
        @(negedge clk);
        rx_push = 1'b0;
        @(negedge clk); #1;
        note_irq(old_mis);
    endtask

    task automatic agent_pop();
        logic [1:0] old_mis;
        logic       exp_av;
        old_mis = m_raw & m_mask;
        exp_av  = (txq.size() != 0);
        @(negedge clk);
        tx_pop = 1'b1;
        #3;
        chk("R13 tx_avail", {31'h0, tx_avail}, {31'h0, exp_av});
        if (exp_av) begin
            chk("R13 tx_data order", {24'h0, tx_data}, {24'h0, txq[0]});
            void'(txq.pop_front());
            m_raw[1] = 1'b1;
        end
        @(negedge clk);
        tx_pop = 1'b0;
        @(negedge clk); #1;
        note_irq(old_mis);
    endtask

    task automatic check_state();
        access(1'b0, A_FLAG, '0);
        access(1'b0, A_RAW, '0);
        access(1'b0, A_MIS, '0);
        access(1'b0, A_MASK, '0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // Reset state (R3 flags 0x05, R9 mask 0, R10 irq low, R13 nothing queued).
        chk("R10 irq at reset", {31'h0, irq}, 32'h0);
        chk("R13 tx_avail at reset", {31'h0, tx_avail}, 32'h0);
        check_state();

        // Sweep every mask value over fill, overflow, drain and underflow.
        for (int m = 0; m < 4; m++) begin
            access(1'b1, A_MASK, 32'hFFFF_FFFC | m);
            for (int i = 0; i <= D; i++) begin
                agent_push(8'(16 * m + i + 1));
                check_state();
            end
            for (int i = 0; i <= D; i++) begin
                access(1'b0, A_DATA, '0);
                check_state();
            end
            for (int i = 0; i <= D; i++) begin
                access(1'b1, A_DATA, 32'hABCD_0000 | (32'(m) << 4) | 32'(i));
                check_state();
            end
            for (int i = 0; i <= D; i++) begin
                agent_pop();
                check_state();
            end
            // R8: every clear pattern with both raw bits set.
            for (int c = 0; c < 4; c++) begin
                agent_push(8'hC0 + 8'(c));
                access(1'b1, A_DATA, 32'h0000_0070 | 32'(c));
                agent_pop();
                access(1'b1, A_CLR, 32'(c));
                check_state();
            end
            while (rxq.size() > 0) access(1'b0, A_DATA, '0);
            check_state();
        end

        // R7: ignored writes and the receive-status word.
        access(1'b1, A_FLAG, 32'hFFFF_FFFF);
        access(1'b1, A_RAW, 32'hFFFF_FFFF);
        access(1'b1, A_MIS, 32'hFFFF_FFFF);
        access(1'b1, A_RSTAT, 32'hFFFF_FFFF);
        access(1'b0, A_RSTAT, '0);
        check_state();

        // R8: a read of the clear register is rejected.
        access(1'b0, A_CLR, '0);

        // R12: every unmapped offset, read and write.
        for (int a = 0; a < 32; a++) begin
            if (!mapped(5'(a))) begin
                access(1'b0, 5'(a), '0);
                access(1'b1, 5'(a), 32'hFFFF_FFFF);
            end
        end
        check_state();

        // R11: receive bit falls and rises again, two pulses.
        access(1'b1, A_MASK, 32'h1);
        p0 = pulses;
        agent_push(8'h5A);
        access(1'b0, A_DATA, '0);
        agent_push(8'hA5);
        chk("R11 re-assert pulses", pulses - p0, 2);
        access(1'b0, A_DATA, '0);

        // R13: pop on an empty outgoing queue is ignored.
        agent_pop();
        check_state();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule